// File: doc/BRIEF.md
# Between-Sample Glitch Detector

This block watches a group of logic channels that are oversampled several times for each main sample period. On each main sample strobe every channel delivers a vector of sub-sample bits, taken at finer time steps than the main sample. The block counts how many times each channel changes level within that one period. A steady level or a single clean edge is normal. Two or more changes between two consecutive main samples mean that a pulse came and went unseen, and the block reports that as a glitch.

Each period yields one glitch bit per channel, aligned to the main sample, so a capture store can keep it next to the sampled data. An enable mask selects which channels may raise a combined trigger pulse. A capture engine can use that pulse to stop on the glitch while keeping the history that led up to it.

The sub-sample vector of a channel holds the earliest sub-sample at bit 0 and the latest at bit N-1. The last sub-sample of one period is carried over, so a change at the period boundary is counted as well.

Top module: `glitch_flagger`

## Requirements
- R1: While `rst_n` is low, `glitch_flag`, `flag_valid` and `glitch_trig` are all 0, and the carried-over level of every channel is cleared to 0.
- R2: On a cycle with `smp_valid` high, the crossings of channel c are counted over adjacent pairs of its sub-samples `sub_bits[c*NSUB +: NSUB]`, where bit 0 is the earliest. The channel is flagged when the count is MIN_CROSS (default 2) or more.
- R3: The step from the carried-over level (bit NSUB-1 of the channel's previous strobed vector, or 0 after reset) to bit 0 of the current vector counts as one crossing.
- R4: A period with 0 or 1 crossings leaves the channel's flag at 0. This covers a steady level and a single edge, including a single edge at the boundary.
- R5: `glitch_flag` takes its new value on the clock edge that samples `smp_valid` high. `flag_valid` is high for exactly the following cycle. `glitch_flag` holds its value until the next strobe.
- R6: While `smp_valid` is low, `sub_bits` has no effect: the flags do not change, and the carried-over level is not updated.
- R7: `glitch_trig` is high for one cycle, one cycle after `flag_valid`, exactly when some channel has `glitch_flag` set and its `trig_mask` bit is 1. The mask is sampled in the `flag_valid` cycle.
- R8: Channels are independent. A glitch on one channel never sets the flag of another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | Main sample strobe; sub-sample vectors are valid |
| sub_bits | input | NCH*NSUB | Per-channel sub-sample vectors, channel c at [c*NSUB +: NSUB], bit 0 earliest |
| trig_mask | input | NCH | Per-channel enable for the combined trigger |
| glitch_flag | output | NCH | Per-channel glitch result of the last strobed period |
| flag_valid | output | 1 | One-cycle pulse: `glitch_flag` was just updated |
| glitch_trig | output | 1 | One-cycle combined glitch trigger pulse |

## Verification
Flags and `flag_valid` are due one cycle after the strobe is sampled. The trigger is due two cycles after the strobe, that is, one cycle after `flag_valid`. The bench drives every input on the falling edge and holds the strobe for a single cycle. It reads the flags at the next falling edge and the trigger at the falling edge after that, and at that second read it also checks that `flag_valid` has dropped again. The expected flags in the vector table are worked out by hand from the carried-over level of each channel, so the order of the table entries matters for the boundary cases.

// File: rtl/glitch_pkg.sv
package glitch_pkg;
   localparam int unsigned MAX_SUB = 64;

   // number of set bits in a vector of up to MAX_SUB bits
   function automatic int unsigned ones_in(input logic [MAX_SUB-1:0] v);
      int unsigned n;
      n = 0;
      for (int i = 0; i < MAX_SUB; i++) begin
         n = n + int'(v[i]);
      end
      return n;
   endfunction
endpackage

// File: rtl/glitch_chan.sv
module glitch_chan #(
   parameter int unsigned NSUB      = 8,
   parameter int unsigned MIN_CROSS = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            strobe,
   input  logic [NSUB-1:0] sub,
   output logic            flag
);
   import glitch_pkg::*;

   localparam int unsigned CW = $clog2(NSUB + 2);

   logic                    last_q;
   logic [NSUB-1:0]         chg;
   logic [MAX_SUB-1:0]      chg_wide;
   logic [CW-1:0]           cross_cnt;
   logic                    is_glitch;

   // change vector: bit 0 is the boundary step, bit i the step into sub[i]
   always_comb begin
      chg[0] = sub[0] ^ last_q;
      for (int i = 1; i < NSUB; i++) begin
         chg[i] = sub[i] ^ sub[i-1];
      end
      chg_wide = '0;
      chg_wide[NSUB-1:0] = chg;
      cross_cnt = CW'(ones_in(chg_wide));
      is_glitch = (cross_cnt >= CW'(MIN_CROSS));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         last_q <= 1'b0;
         flag   <= 1'b0;
      end else if (strobe) begin
         last_q <= sub[NSUB-1];
         flag   <= is_glitch;
      end
   end

   // R4: period matching the carried level gives no glitch
   a_r4_steady_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe && (sub == {NSUB{last_q}})) |=> !flag);

   // R3: boundary step plus one more step right after it is a glitch
   a_r3_boundary_counts: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe && (sub[0] != last_q) && (sub[1] != sub[0])) |=> flag);

   // R6: no strobe, no change of flag or carried level
   a_r6_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !strobe |=> ($stable(flag) && $stable(last_q)));
endmodule

// File: rtl/glitch_trig.sv
module glitch_trig #(
   parameter int unsigned NCH = 8
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           upd,
   input  logic [NCH-1:0] flags,
   input  logic [NCH-1:0] mask,
   output logic           trig
);
   logic [NCH-1:0] hit;

   assign hit = flags & mask;

   always_ff @(posedge clk) begin
      if (!rst_n) trig <= 1'b0;
      else        trig <= upd && (|hit);
   end

   // R7: the trigger is a single-cycle pulse
   a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      trig |=> !trig);
endmodule

// File: rtl/glitch_flagger.sv
module glitch_flagger #(
   parameter int unsigned NCH       = 8,
   parameter int unsigned NSUB      = 8,
   parameter int unsigned MIN_CROSS = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                smp_valid,
   input  logic [NCH*NSUB-1:0] sub_bits,
   input  logic [NCH-1:0]      trig_mask,
   output logic [NCH-1:0]      glitch_flag,
   output logic                flag_valid,
   output logic                glitch_trig
);
   initial begin
      assert (NCH >= 1) else $error("NCH must be at least 1");
      assert (NSUB >= 2 && NSUB <= glitch_pkg::MAX_SUB) else $error("NSUB out of range");
      assert (MIN_CROSS >= 2 && MIN_CROSS <= NSUB) else $error("MIN_CROSS out of range");
   end

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      glitch_chan #(
         .NSUB      (NSUB),
         .MIN_CROSS (MIN_CROSS)
      ) u_chan (
         .clk    (clk),
         .rst_n  (rst_n),
         .strobe (smp_valid),
         .sub    (sub_bits[c*NSUB +: NSUB]),
         .flag   (glitch_flag[c])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n) flag_valid <= 1'b0;
      else        flag_valid <= smp_valid;
   end

   glitch_trig #(.NCH(NCH)) u_trig (
      .clk   (clk),
      .rst_n (rst_n),
      .upd   (flag_valid),
      .flags (glitch_flag),
      .mask  (trig_mask),
      .trig  (glitch_trig)
   );

   // R5: flag_valid only follows a strobe
   a_r5_valid_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      flag_valid |-> $past(smp_valid));

   // R7: trigger only after an update carrying some flag
   a_r7_trig_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
      glitch_trig |-> ($past(flag_valid) && $past(|glitch_flag)));
endmodule

// File: tb/glitch_flagger_tb.sv
module glitch_flagger_tb;
   localparam int NCH  = 8;
   localparam int NSUB = 8;
   localparam int W    = NCH*NSUB;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           smp_valid = 1'b0;
   logic [W-1:0]   sub_bits = '0;
   logic [NCH-1:0] trig_mask = '0;
   logic [NCH-1:0] glitch_flag;
   logic           flag_valid;
   logic           glitch_trig;

   int total = 0;
   int bad   = 0;

   always #2 clk = ~clk;

   glitch_flagger #(.NCH(NCH), .NSUB(NSUB)) u_dut (
      .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .sub_bits(sub_bits),
      .trig_mask(trig_mask), .glitch_flag(glitch_flag),
      .flag_valid(flag_valid), .glitch_trig(glitch_trig)
   );

   // {sub_bits, mask, expected flags, expected trig}; byte c is channel c, bit 0 earliest
   localparam int VW = W + NCH + NCH + 1;
   localparam logic [VW-1:0] VEC [6] = '{
      {64'h00_00_00_00_00_00_00_00, 8'hFF, 8'h00, 1'b0},
      {64'h3C_80_00_0F_F0_02_01_FF, 8'h01, 8'h96, 1'b0},
      {64'hFF_FF_00_00_FE_55_FF_00, 8'h08, 8'h0C, 1'b1},
      {64'hFF_FF_FF_FF_FF_FF_FF_FF, 8'hFF, 8'h00, 1'b0},
      {64'h7F_7F_7E_7F_7F_7F_7F_7F, 8'hDF, 8'h20, 1'b0},
      {64'h00_00_7E_00_00_00_00_00, 8'h20, 8'h20, 1'b1}
   };

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic apply(input logic [W-1:0] bits, input logic [NCH-1:0] m,
                        input logic [NCH-1:0] eflag, input logic etrig, input string req);
      @(negedge clk);
      sub_bits = bits; trig_mask = m; smp_valid = 1'b1;
      @(negedge clk);
      smp_valid = 1'b0;
      sub_bits = ~bits;
      chk(flag_valid === 1'b1, {req, " R5 valid"}, 64'(flag_valid), 64'd1);
      chk(glitch_flag === eflag, {req, " R2 flags"}, 64'(glitch_flag), 64'(eflag));
      chk(glitch_trig === 1'b0, {req, " R7 trig early"}, 64'(glitch_trig), 64'd0);
      @(negedge clk);
      chk(glitch_trig === etrig, {req, " R7 trig"}, 64'(glitch_trig), 64'(etrig));
      chk(flag_valid === 1'b0, {req, " R5 valid drop"}, 64'(flag_valid), 64'd0);
      chk(glitch_flag === eflag, {req, " R5 hold"}, 64'(glitch_flag), 64'(eflag));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      bad++; total++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      // R1 reset state
      repeat (3) @(negedge clk);
      chk(glitch_flag === '0 && flag_valid === 1'b0 && glitch_trig === 1'b0,
          "R1 reset outputs", {glitch_flag, flag_valid, glitch_trig}, 64'd0);
      @(negedge clk);
      rst_n = 1'b1;

      // R2 R3 R4 R8 vector table
      for (int i = 0; i < 6; i++) begin
         apply(VEC[i][VW-1 -: W], VEC[i][2*NCH : NCH+1], VEC[i][NCH:1], VEC[i][0], $sformatf("vec%0d R8", i));
      end

      // R6: idle garbage with bit 7 high must not move flags nor carried level
      for (int k = 0; k < 4; k++) begin
         @(negedge clk);
         sub_bits = {NCH{8'h80}} ^ W'(k);
         trig_mask = '1;
      end
      @(negedge clk);
      chk(glitch_flag === 8'h20, "R6 flags idle", 64'(glitch_flag), 64'h20);
      chk(glitch_trig === 1'b0, "R6 no trig idle", 64'(glitch_trig), 64'd0);
      // carried level still 0: 0x01 gives boundary edge plus fall = glitch on all
      apply({NCH{8'h01}}, 8'hFF, 8'hFF, 1'b1, "R6 R3 level kept");
      // R4 single boundary edge only (carried 0 -> all ones)
      apply({NCH{8'hFF}}, 8'hFF, 8'h00, 1'b0, "R4 single edge");
      // R2 alternating pattern on one channel, mask off -> no trig
      apply(64'h00_00_00_AA_FF_FF_FF_FF, 8'hEF, 8'h10, 1'b0, "R2 R7 masked");

      // R1 reset mid-run clears flags and carried level
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      chk(glitch_flag === '0 && flag_valid === 1'b0 && glitch_trig === 1'b0,
          "R1 mid reset", {glitch_flag, flag_valid, glitch_trig}, 64'd0);
      rst_n = 1'b1;
      // carried level 0 after reset: 0x01 per channel is a glitch again
      apply({NCH{8'h01}}, 8'h00, 8'hFF, 1'b0, "R1 level cleared");

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule